// File: doc/BRIEF.md
# Downward-Growing Stack Pointer Unit

This block holds the stack pointer of a small 8-bit processor whose stack grows from high addresses toward low ones. The core raises one of four one-hot requests per cycle: push a data byte, pop a data byte, push a two-byte return address (call or interrupt entry), or pop a two-byte return address (return or interrupt return). For every byte moved, the unit presents the data-memory address to use and whether it is a write or a read. It then steps the pointer so that it again names the current top of the stack.

Return-address transfers take two consecutive cycles, one byte each. On a push, the low byte goes first, to the higher address. On a pop the order is reversed, so the high byte is read first. Software sees the pointer as a low and a high 8-bit I/O register. The number of implemented bits is a parameter between 8 and 16. Unimplemented bits read as zero, and with 8 bits the high register does not exist. Firmware must load a pointer above 0x0100 before any call or interrupt is taken.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset, the pointer equals the parameter RESET_VAL, and acc_valid_o, busy_o and err_o are 0.
- R2: A byte push presents a write access (acc_valid_o=1, acc_write_o=1) at the current pointer in the same cycle, and the pointer reads one lower after the next clock.
- R3: A byte pop presents a read access (acc_write_o=0) at pointer+1 in the same cycle, and the pointer reads one higher after the next clock.
- R4: A return-address push gives two write cycles: first at P with acc_hi_o=0, then at P-1 with acc_hi_o=1 and busy_o=1. Afterwards the pointer is P-2.
- R5: A return-address pop gives two read cycles: first at P+1 with acc_hi_o=1, then at P+2 with acc_hi_o=0 and busy_o=1. Afterwards the pointer is P+2.
- R6: io_lo_o shows pointer bits 7:0 and io_hi_o shows bits 15:8. Unimplemented bits read 0, and io_hi_o is always 0 when PTR_W is 8.
- R7: io_wr_lo_i or io_wr_hi_i loads io_wdata_i into the matching pointer byte on the next clock. Bits above PTR_W are dropped, so a high-byte write has no effect when PTR_W is 8.
- R8: An I/O write has priority over stack operations. In that cycle no access is presented, the pointer takes only the written value, and any second byte still pending is cancelled.
- R9: More than one request at once, or any request while busy_o=1, raises err_o in that cycle. The offending request is ignored, but a second byte already in progress still completes.
- R10: Pointer arithmetic and access addresses wrap modulo 2^PTR_W. acc_addr_o is zero-extended to 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_byte_i | input | 1 | Push one data byte |
| pop_byte_i | input | 1 | Pop one data byte |
| push_ret_i | input | 1 | Push a two-byte return address |
| pop_ret_i | input | 1 | Pop a two-byte return address |
| io_wr_lo_i | input | 1 | Write strobe, pointer low byte |
| io_wr_hi_i | input | 1 | Write strobe, pointer high byte |
| io_wdata_i | input | 8 | I/O write data |
| io_lo_o | output | 8 | Pointer low byte readback |
| io_hi_o | output | 8 | Pointer high byte readback |
| acc_valid_o | output | 1 | A stack memory access happens this cycle |
| acc_write_o | output | 1 | 1 = write (push), 0 = read (pop) |
| acc_hi_o | output | 1 | Access carries the high byte of a return address |
| acc_addr_o | output | 16 | Data-memory address of the access |
| busy_o | output | 1 | Second byte of a return-address transfer in progress |
| err_o | output | 1 | Illegal request combination |

## Verification
A wrong pointer state shows on io_lo_o and io_hi_o one clock after the operation that produced it. It also shows in the same cycle on acc_addr_o for the next access, so an off-by-one step or a wrong wrap cannot hide for long. A sequencer stuck in its second phase shows up as busy_o held high, as a spurious acc_valid_o, or as an err_o raised on a legal request. A dropped phase shows as a pointer one off after a return-address transfer. Every starting pointer of a 10-bit configuration is swept through all four operations, and an 8-bit configuration runs beside it to cover the missing high byte.

// File: rtl/sp_pkg.sv
package sp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PUSH2 = 2'd1,
        ST_POP2  = 2'd2
    } seq_st_e;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_DEC  = 2'd1,
        STEP_INC  = 2'd2
    } step_e;

    localparam int unsigned IO_W   = 8;
    localparam int unsigned ADDR_W = 16;

endpackage

// File: rtl/sp_seq.sv
module sp_seq
    import sp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  req_push_b,
    input  logic  req_pop_b,
    input  logic  req_call,
    input  logic  req_ret,
    input  logic  io_any,
    output step_e step,
    output logic  acc_valid,
    output logic  acc_write,
    output logic  acc_hi,
    output logic  busy,
    output logic  err
);

    typedef struct packed {
        seq_st_e st;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [2:0] nreq;

    always_comb begin
        nreq      = 3'($countones({req_push_b, req_pop_b, req_call, req_ret}));
        seq_d     = seq_q;
        step      = STEP_NONE;
        acc_valid = 1'b0;
        acc_write = 1'b0;
        acc_hi    = 1'b0;
        busy      = (seq_q.st != ST_IDLE);
        err       = (nreq > 3'd1) || (busy && (nreq != 3'd0));

        case (seq_q.st)
            ST_PUSH2: begin
                acc_valid = 1'b1;
                acc_write = 1'b1;
                acc_hi    = 1'b1;
                step      = STEP_DEC;
                seq_d.st  = ST_IDLE;
            end
            ST_POP2: begin
                acc_valid = 1'b1;
                step      = STEP_INC;
                seq_d.st  = ST_IDLE;
            end
            default: begin
                if (!err) begin
                    if (req_push_b) begin
                        acc_valid = 1'b1;
                        acc_write = 1'b1;
                        step      = STEP_DEC;
                    end else if (req_pop_b) begin
                        acc_valid = 1'b1;
                        step      = STEP_INC;
                    end else if (req_call) begin
                        acc_valid = 1'b1;
                        acc_write = 1'b1;
                        step      = STEP_DEC;
                        seq_d.st  = ST_PUSH2;
                    end else if (req_ret) begin
                        acc_valid = 1'b1;
                        acc_hi    = 1'b1;
                        step      = STEP_INC;
                        seq_d.st  = ST_POP2;
                    end
                end
            end
        endcase

        if (io_any) begin
            acc_valid = 1'b0;
            acc_write = 1'b0;
            acc_hi    = 1'b0;
            step      = STEP_NONE;
            seq_d.st  = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE};
        else        seq_q <= seq_d;
    end

    // R4: a legal call is followed by the high-byte write phase
    p_call_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_IDLE && req_call && nreq == 3'd1 && !io_any)
        |=> (acc_valid && acc_write && acc_hi) || io_any);

    // R5: a legal return is followed by the low-byte read phase
    p_ret_second_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_IDLE && req_ret && nreq == 3'd1 && !io_any)
        |=> (acc_valid && !acc_write && !acc_hi) || io_any);

    // R9: an illegal request from idle produces no access
    p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !busy) |-> !acc_valid && step == STEP_NONE);

    // R8: I/O write suppresses any access and clears the sequence
    p_io_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        io_any |-> !acc_valid ##1 !busy);

endmodule

// File: rtl/sp_reg.sv
module sp_reg
    import sp_pkg::*;
#(
    parameter int unsigned         PTR_W     = 12,
    parameter logic [PTR_W-1:0]    RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_e            step,
    input  logic             io_wr_lo,
    input  logic             io_wr_hi,
    input  logic [IO_W-1:0]  io_wdata,
    output logic [PTR_W-1:0] sp,
    output logic [IO_W-1:0]  rd_lo,
    output logic [IO_W-1:0]  rd_hi
);

    localparam bit HAS_HI = (PTR_W > IO_W);

    typedef struct packed {
        logic [PTR_W-1:0] sp;
    } reg_t;

    reg_t reg_d, reg_q;
    logic [ADDR_W-1:0] wide_q, wide_n;

    always_comb begin
        wide_q = ADDR_W'(reg_q.sp);
        reg_d  = reg_q;
        if (io_wr_lo || io_wr_hi) begin
            wide_n = wide_q;
            if (io_wr_lo) wide_n[7:0]  = io_wdata;
            if (io_wr_hi) wide_n[15:8] = io_wdata;
        end else begin
            case (step)
                STEP_DEC: wide_n = wide_q - ADDR_W'(1);
                STEP_INC: wide_n = wide_q + ADDR_W'(1);
                default:  wide_n = wide_q;
            endcase
        end
        reg_d.sp = wide_n[PTR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) reg_q <= '{sp: RESET_VAL};
        else        reg_q <= reg_d;
    end

    assign sp    = reg_q.sp;
    assign rd_lo = wide_q[7:0];

    generate
        if (HAS_HI) begin : g_hi
            assign rd_hi = wide_q[15:8];
        end else begin : g_no_hi
            assign rd_hi = '0;
        end
    endgenerate

    // R2: decrement by one per push step
    p_step_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_DEC && !io_wr_lo && !io_wr_hi)
        |=> reg_q.sp == PTR_W'($past(reg_q.sp) - PTR_W'(1)));

    // R3: increment by one per pop step
    p_step_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_INC && !io_wr_lo && !io_wr_hi)
        |=> reg_q.sp == PTR_W'($past(reg_q.sp) + PTR_W'(1)));

    // R7: low-byte write lands on the next clock
    p_wr_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr_lo |=> rd_lo == $past(io_wdata));

    // R9: no step and no write keeps the pointer
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_NONE && !io_wr_lo && !io_wr_hi) |=> $stable(reg_q.sp));

endmodule

// File: rtl/sp_addr.sv
module sp_addr
    import sp_pkg::*;
#(
    parameter int unsigned PTR_W = 12
) (
    input  logic [PTR_W-1:0]  sp,
    input  step_e             step,
    output logic [ADDR_W-1:0] addr
);

    logic [PTR_W-1:0] eff;

    always_comb begin
        eff  = (step == STEP_INC) ? PTR_W'(sp + PTR_W'(1)) : sp;
        addr = ADDR_W'(eff);
    end

endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
    import sp_pkg::*;
#(
    parameter int unsigned      PTR_W     = 12,
    parameter logic [PTR_W-1:0] RESET_VAL = 12'h8FF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_byte_i,
    input  logic        pop_byte_i,
    input  logic        push_ret_i,
    input  logic        pop_ret_i,
    input  logic        io_wr_lo_i,
    input  logic        io_wr_hi_i,
    input  logic [7:0]  io_wdata_i,
    output logic [7:0]  io_lo_o,
    output logic [7:0]  io_hi_o,
    output logic        acc_valid_o,
    output logic        acc_write_o,
    output logic        acc_hi_o,
    output logic [15:0] acc_addr_o,
    output logic        busy_o,
    output logic        err_o
);

    step_e            step;
    logic [PTR_W-1:0] sp_cur;
    logic             io_any;

    assign io_any = io_wr_lo_i | io_wr_hi_i;

    sp_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_push_b (push_byte_i),
        .req_pop_b  (pop_byte_i),
        .req_call   (push_ret_i),
        .req_ret    (pop_ret_i),
        .io_any     (io_any),
        .step       (step),
        .acc_valid  (acc_valid_o),
        .acc_write  (acc_write_o),
        .acc_hi     (acc_hi_o),
        .busy       (busy_o),
        .err        (err_o)
    );

    sp_reg #(.PTR_W(PTR_W), .RESET_VAL(RESET_VAL)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .io_wr_lo (io_wr_lo_i),
        .io_wr_hi (io_wr_hi_i),
        .io_wdata (io_wdata_i),
        .sp       (sp_cur),
        .rd_lo    (io_lo_o),
        .rd_hi    (io_hi_o)
    );

    sp_addr #(.PTR_W(PTR_W)) u_addr (
        .sp   (sp_cur),
        .step (step),
        .addr (acc_addr_o)
    );

    // R4: the second write of a call sits one below the first
    p_call_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_o && acc_write_o && !acc_hi_o && !busy_o && push_ret_i)
        |=> !acc_valid_o || acc_addr_o == 16'(PTR_W'($past(acc_addr_o) - 16'd1)));

    // R10: access addresses never exceed the implemented range
    p_addr_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_o |-> (acc_addr_o >> PTR_W) == 16'd0);

endmodule

// File: tb/stack_ptr_unit_tb.sv
module stack_ptr_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W = 10;
    localparam int M = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_b = 0, pop_b = 0, push_r = 0, pop_r = 0;
    logic wr_lo = 0, wr_hi = 0;
    logic [7:0] wdata = 0;
    logic [7:0] lo, hi, lo8, hi8;
    logic av, aw, ah, bsy, er, av8, aw8, ah8, bsy8, er8;
    logic [15:0] addr, addr8;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stack_ptr_unit #(.PTR_W(W), .RESET_VAL(10'h3FF)) dut_i (
        .clk(clk), .rst_n(rst_n), .push_byte_i(push_b), .pop_byte_i(pop_b),
        .push_ret_i(push_r), .pop_ret_i(pop_r), .io_wr_lo_i(wr_lo),
        .io_wr_hi_i(wr_hi), .io_wdata_i(wdata), .io_lo_o(lo), .io_hi_o(hi),
        .acc_valid_o(av), .acc_write_o(aw), .acc_hi_o(ah), .acc_addr_o(addr),
        .busy_o(bsy), .err_o(er));

    stack_ptr_unit #(.PTR_W(8), .RESET_VAL(8'hF0)) dut8_i (
        .clk(clk), .rst_n(rst_n), .push_byte_i(push_b), .pop_byte_i(pop_b),
        .push_ret_i(push_r), .pop_ret_i(pop_r), .io_wr_lo_i(wr_lo),
        .io_wr_hi_i(wr_hi), .io_wdata_i(wdata), .io_lo_o(lo8), .io_hi_o(hi8),
        .acc_valid_o(av8), .acc_write_o(aw8), .acc_hi_o(ah8), .acc_addr_o(addr8),
        .busy_o(bsy8), .err_o(er8));

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int ptr();
        return {hi, lo};
    endfunction

    task automatic set_ptr(input logic [15:0] v);
        @(negedge clk); wr_lo = 1; wdata = v[7:0];
        @(negedge clk); wr_lo = 0; wr_hi = 1; wdata = v[15:8];
        @(negedge clk); wr_hi = 0;
    endtask

    // k: 0 byte push, 1 byte pop, 2 return push, 3 return pop
    task automatic run_op(input int k, input int v);
        push_b = (k == 0); pop_b = (k == 1); push_r = (k == 2); pop_r = (k == 3);
        #1;
        check("R2/R3/R4/R5 valid", av, 1);
        case (k)
            0: begin check("R2 addr", addr, v); check("R2 write", aw, 1); end
            1: begin check("R3 addr", addr, (v + 1) & M); check("R3 read", aw, 0); end
            2: begin check("R4 addr1", addr, v); check("R4 hi1", ah, 0); check("R4 write1", aw, 1); end
            default: begin check("R5 addr1", addr, (v + 1) & M); check("R5 hi1", ah, 1); check("R5 read1", aw, 0); end
        endcase
        @(negedge clk);
        push_b = 0; pop_b = 0; push_r = 0; pop_r = 0;
        if (k >= 2) begin
            #1;
            check("R4/R5 busy", bsy, 1);
            check("R4/R5 valid2", av, 1);
            if (k == 2) begin
                check("R4 addr2", addr, (v - 1) & M); check("R4 hi2", ah, 1); check("R4 write2", aw, 1);
            end else begin
                check("R5 addr2", addr, (v + 2) & M); check("R5 hi2", ah, 0); check("R5 read2", aw, 0);
            end
            @(negedge clk);
        end
        case (k)
            0: check("R2 ptr R10", ptr(), (v - 1) & M);
            1: check("R3 ptr R10", ptr(), (v + 1) & M);
            2: check("R4 ptr", ptr(), (v - 2) & M);
            default: check("R5 ptr", ptr(), (v + 2) & M);
        endcase
        check("R9 busy clear", bsy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=expired expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        // R1 reset state
        check("R1 ptr", ptr(), 16'h3FF);
        check("R1 ptr8", {hi8, lo8}, 16'h00F0);
        check("R1 valid", av, 0);
        check("R1 busy", bsy, 0);
        check("R1 err", er, 0);

        // R6/R7 readback and masking of unimplemented bits
        set_ptr(16'hFFAB); #1;
        check("R6 lo", lo, 8'hAB);
        check("R6 R7 hi mask", hi, 8'h03);
        check("R6 R7 hi absent", hi8, 8'h00);
        check("R7 lo8", lo8, 8'hAB);

        // exhaustive sweep: every pointer value through every operation
        for (int v = 0; v <= M; v++) begin
            for (int k = 0; k < 4; k++) begin
                set_ptr(16'(v));
                check("R6 R7 load", ptr(), v);
                run_op(k, v);
            end
        end

        // R9: two requests at once are ignored and flagged
        set_ptr(16'h0155);
        push_b = 1; pop_b = 1; #1;
        check("R9 err multi", er, 1);
        check("R9 no access", av, 0);
        @(negedge clk); push_b = 0; pop_b = 0; #1;
        check("R9 ptr kept", ptr(), 16'h155);
        check("R9 err clear", er, 0);

        // R9: request while busy flagged, second phase completes
        set_ptr(16'h0200);
        push_r = 1;
        @(negedge clk); push_r = 0; pop_b = 1; #1;
        check("R9 err busy", er, 1);
        check("R9 phase2 valid", av, 1);
        check("R9 phase2 addr", addr, 16'h1FF);
        check("R9 phase2 hi", ah, 1);
        @(negedge clk); pop_b = 0; #1;
        check("R9 ptr after", ptr(), 16'h1FE);
        check("R9 busy done", bsy, 0);

        // R8: I/O write beats a byte push
        set_ptr(16'h0100);
        push_b = 1; wr_lo = 1; wdata = 8'h42; #1;
        check("R8 no access", av, 0);
        @(negedge clk); push_b = 0; wr_lo = 0; #1;
        check("R8 ptr written", ptr(), 16'h142);

        // R8: I/O write cancels pending second phase of a call
        set_ptr(16'h0300);
        push_r = 1;
        @(negedge clk); push_r = 0; wr_lo = 1; wdata = 8'h77; #1;
        check("R8 cancel access", av, 0);
        @(negedge clk); wr_lo = 0; #1;
        check("R8 cancel ptr", ptr(), 16'h277);
        check("R8 cancel busy", bsy, 0);
        check("R8 cancel valid", av, 0);

        // R7 R10: 8-bit configuration, high write ignored, wrap at zero
        set_ptr(16'h1200); #1;
        check("R7 hi8 ignored", {hi8, lo8}, 16'h0000);
        push_b = 1; #1;
        check("R10 addr8", addr8, 16'h0000);
        check("R2 addr main", addr, 16'h0200);
        @(negedge clk); push_b = 0; #1;
        check("R10 wrap8", {hi8, lo8}, 16'h00FF);
        check("R2 main ptr", ptr(), 16'h1FF);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule